// File: doc/BRIEF.md
# Pre-Add Multiply-Accumulate Slice

This block is one arithmetic slice of a datapath. It forms a product M from an 18-bit signed operand B and a pre-adder result, either A + D or A − D. It then combines M with a selectable 48-bit operand Z in a post-adder. Z can be zero, a cascade input from a neighbouring slice, the slice's own registered result, or an external operand C. The pre-adder stage can be removed at build time. In that case the product is B × A and the pipeline is one stage shorter.

A 5-bit mode word is issued with the operands and travels down the pipeline beside them, so each mode value acts on its own operands. Each pipeline stage has its own clock enable. The full registered result leaves on a cascade output that a downstream slice can take as its cascade input. The main result output can drop a chosen number of low bits. Tying the Z select to the feedback path makes the slice a running accumulator, and selecting C restarts the sum.

Top module: `pre_add_mac`

## Requirements
- R1: While rst_ni is low, every pipeline register is cleared, so p_o and pcout_o read zero. The reset is active-low and asynchronous.
- R2: With the pre-adder built (USE_PREADD=1), M = B × (A + D) when mode bit 4 is 0, and M = B × (A − D) when mode bit 4 is 1.
- R3: Mode bits [1:0] select the post-adder operation: 0 gives Z + M, 1 gives M − Z, 2 gives −(Z + M + 1), which is the bitwise inverse of Z + M, and 3 gives Z − M.
- R4: Mode bits [3:2] select Z: 0 selects zero, 1 selects pcin_i as it stands at the edge that loads P, 2 selects the current P register, and 3 selects the C value issued with the operands.
- R5: A result appears on the outputs after the fourth rising edge following the operands with the pre-adder built, and after the third without it. C and the mode word are delayed by the same number of stages.
- R6: ce1_i enables the operand stage, ce2_i the pre-adder stage, cem_i the product register and cep_i the result register. A stage whose enable is low keeps its contents.
- R7: pcout_o carries the whole 48-bit result register. p_o carries bits [47:S] of it.
- R8: All arithmetic is two's complement modulo 2^48, with no saturation.
- R9: With USE_PREADD=0, M = B × A, and d_i, mode bit 4 and ce2_i have no effect on the outputs.
- R10: As an accumulator, mode 5'b01100 loads P with C + M, and mode 5'b01000 adds M to the current P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce1_i | input | 1 | Operand stage enable |
| ce2_i | input | 1 | Pre-adder stage enable |
| cem_i | input | 1 | Product register enable |
| cep_i | input | 1 | Result register enable |
| a_i | input | 25 | Signed operand A |
| b_i | input | 18 | Signed operand B |
| c_i | input | 48 | Signed operand C |
| d_i | input | 25 | Signed pre-adder operand D |
| mode_i | input | 5 | {pre-sub, Z select[1:0], op[1:0]} |
| pcin_i | input | 48 | Cascade input |
| pcout_o | output | 48 | Full registered result |
| p_o | output | 48-S | Result bits [47:S] |

## Verification
The assertions assume that pcin_i, C and the mode word are known, non-X values whenever the stage that consumes them is enabled. They also assume that reset is asserted only once, at the start. The bench keeps within these limits: it drives every input to a defined value at all times, releases reset once, and never asserts it again. The sequences it applies are random operands with random modes, random clock-enable patterns, an accumulator restart, and extreme operand values held until the result wraps. These are applied at the same time to a slice with the pre-adder and to a slice without it, and the second slice drops four low bits.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_ADD     = 2'd0,
    OP_M_MIN_Z = 2'd1,
    OP_NOT_SUM = 2'd2,
    OP_Z_MIN_M = 2'd3
  } alu_op_e;

  typedef enum logic [1:0] {
    Z_ZERO = 2'd0,
    Z_CASC = 2'd1,
    Z_FB   = 2'd2,
    Z_EXT  = 2'd3
  } zsel_e;

  typedef struct packed {
    logic    pre_sub;
    zsel_e   zsel;
    alu_op_e op;
  } mode_t;
endpackage

// File: rtl/mac_operand_stage.sv
module mac_operand_stage
  import mac_pkg::*;
#(
  parameter int unsigned USE_PREADD = 1,
  parameter int unsigned A_W = 25,
  parameter int unsigned B_W = 18,
  parameter int unsigned P_W = 48
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ce1_i,
  input  logic                  ce2_i,
  input  logic signed [A_W-1:0] a_i,
  input  logic signed [B_W-1:0] b_i,
  input  logic signed [P_W-1:0] c_i,
  input  logic signed [A_W-1:0] d_i,
  input  mode_t                 mode_i,
  output logic signed [A_W:0]   ad_o,
  output logic signed [B_W-1:0] b_o,
  output logic signed [P_W-1:0] c_o,
  output mode_t                 mode_o
);
  logic signed [A_W-1:0] a_q;
  logic signed [B_W-1:0] b_q;
  logic signed [P_W-1:0] c_q;
  mode_t                 mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
      mode_q <= '0;
    end else if (ce1_i) begin
      a_q    <= a_i;
      b_q    <= b_i;
      c_q    <= c_i;
      mode_q <= mode_i;
    end
  end

  generate
    if (USE_PREADD != 0) begin : g_preadd
      logic signed [A_W-1:0] d_q;
      logic signed [A_W:0]   ad_q;
      logic signed [B_W-1:0] b2_q;
      logic signed [P_W-1:0] c2_q;
      mode_t                 mode2_q;
      logic signed [A_W:0]   a_x, d_x;

      assign a_x = {a_q[A_W-1], a_q};
      assign d_x = {d_q[A_W-1], d_q};

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) d_q <= '0;
        else if (ce1_i) d_q <= d_i;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ad_q    <= '0;
          b2_q    <= '0;
          c2_q    <= '0;
          mode2_q <= '0;
        end else if (ce2_i) begin
          ad_q    <= mode_q.pre_sub ? a_x - d_x : a_x + d_x;
          b2_q    <= b_q;
          c2_q    <= c_q;
          mode2_q <= mode_q;
        end
      end

      assign ad_o   = ad_q;
      assign b_o    = b2_q;
      assign c_o    = c2_q;
      assign mode_o = mode2_q;
    end else begin : g_direct
      logic unused_ok;
      assign unused_ok = ^{d_i, ce2_i};
      assign ad_o   = {a_q[A_W-1], a_q};
      assign b_o    = b_q;
      assign c_o    = c_q;
      assign mode_o = mode_q;
    end
  endgenerate
endmodule

// File: rtl/mac_mult_stage.sv
module mac_mult_stage
  import mac_pkg::*;
#(
  parameter int unsigned A_W = 25,
  parameter int unsigned B_W = 18,
  parameter int unsigned P_W = 48
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cem_i,
  input  logic signed [A_W:0]   ad_i,
  input  logic signed [B_W-1:0] b_i,
  input  logic signed [P_W-1:0] c_i,
  input  mode_t                 mode_i,
  output logic signed [P_W-1:0] m_o,
  output logic signed [P_W-1:0] c_o,
  output mode_t                 mode_o
);
  localparam int unsigned M_W = A_W + 1 + B_W;

  logic signed [M_W-1:0] prod;
  assign prod = b_i * ad_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_o    <= '0;
      c_o    <= '0;
      mode_o <= '0;
    end else if (cem_i) begin
      m_o    <= {{(P_W-M_W){prod[M_W-1]}}, prod};
      c_o    <= c_i;
      mode_o <= mode_i;
    end
  end
endmodule

// File: rtl/mac_alu_stage.sv
module mac_alu_stage
  import mac_pkg::*;
#(
  parameter int unsigned P_W = 48
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cep_i,
  input  logic [P_W-1:0] m_i,
  input  logic [P_W-1:0] c_i,
  input  logic [P_W-1:0] pcin_i,
  input  mode_t          mode_i,
  output logic [P_W-1:0] p_o
);
  logic [P_W-1:0] z, sum, res;

  always_comb begin
    unique case (mode_i.zsel)
      Z_ZERO:  z = '0;
      Z_CASC:  z = pcin_i;
      Z_FB:    z = p_o;
      default: z = c_i;
    endcase
  end

  assign sum = z + m_i;

  always_comb begin
    unique case (mode_i.op)
      OP_ADD:     res = sum;
      OP_M_MIN_Z: res = m_i - z;
      OP_NOT_SUM: res = ~sum;
      default:    res = z - m_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p_o <= '0;
    else if (cep_i) p_o <= res;
  end
endmodule

// File: rtl/pre_add_mac.sv
module pre_add_mac
  import mac_pkg::*;
#(
  parameter int unsigned USE_PREADD = 1,
  parameter int unsigned S = 0,
  parameter int unsigned A_W = 25,
  parameter int unsigned B_W = 18,
  parameter int unsigned P_W = 48
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ce1_i,
  input  logic                  ce2_i,
  input  logic                  cem_i,
  input  logic                  cep_i,
  input  logic signed [A_W-1:0] a_i,
  input  logic signed [B_W-1:0] b_i,
  input  logic signed [P_W-1:0] c_i,
  input  logic signed [A_W-1:0] d_i,
  input  logic [4:0]            mode_i,
  input  logic signed [P_W-1:0] pcin_i,
  output logic signed [P_W-1:0] pcout_o,
  output logic signed [P_W-1-S:0] p_o
);
  mode_t                 mode_in, mode_op, mode_m;
  logic signed [A_W:0]   ad_op;
  logic signed [B_W-1:0] b_op;
  logic signed [P_W-1:0] c_op, c_m, m_q;
  logic [P_W-1:0]        p_q;

  assign mode_in = mode_t'(mode_i);

  mac_operand_stage #(.USE_PREADD(USE_PREADD), .A_W(A_W), .B_W(B_W), .P_W(P_W)) i_operand (
    .clk_i, .rst_ni, .ce1_i, .ce2_i, .a_i, .b_i, .c_i, .d_i,
    .mode_i(mode_in), .ad_o(ad_op), .b_o(b_op), .c_o(c_op), .mode_o(mode_op)
  );

  mac_mult_stage #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) i_mult (
    .clk_i, .rst_ni, .cem_i, .ad_i(ad_op), .b_i(b_op), .c_i(c_op),
    .mode_i(mode_op), .m_o(m_q), .c_o(c_m), .mode_o(mode_m)
  );

  mac_alu_stage #(.P_W(P_W)) i_alu (
    .clk_i, .rst_ni, .cep_i, .m_i(m_q), .c_i(c_m), .pcin_i,
    .mode_i(mode_m), .p_o(p_q)
  );

  assign pcout_o = p_q;
  assign p_o     = p_q[P_W-1:S];
endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
  parameter int unsigned P_W = 48
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cem_i,
  input logic           cep_i,
  input logic [P_W-1:0] pcin_i,
  input logic [P_W-1:0] pcout_o,
  input logic [P_W-1:0] m_q,
  input logic [4:0]     mode_q
);
  p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> pcout_o == '0);

  p_hold_p_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cep_i |=> $stable(pcout_o));

  p_hold_m_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cem_i |=> $stable(m_q));

  p_inverted_sum_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cep_i && mode_q[3:2] == 2'd0 && mode_q[1:0] == 2'd2) |=> pcout_o == ~$past(m_q));

  p_cascade_add_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cep_i && mode_q[3:2] == 2'd1 && mode_q[1:0] == 2'd0) |=> pcout_o == $past(pcin_i + m_q));

  p_accumulate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cep_i && mode_q[3:2] == 2'd2 && mode_q[1:0] == 2'd0) |=> pcout_o == $past(pcout_o + m_q));
endmodule

bind pre_add_mac mac_checker #(.P_W(P_W)) i_mac_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .cem_i(cem_i), .cep_i(cep_i),
  .pcin_i(pcin_i), .pcout_o(pcout_o), .m_q(m_q), .mode_q(mode_m)
);

// File: tb/test_pre_add_mac.sv
module test_pre_add_mac;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ce1_i = 1'b0, ce2_i = 1'b0, cem_i = 1'b0, cep_i = 1'b0;
  logic signed [24:0] a_i = '0, d_i = '0;
  logic signed [17:0] b_i = '0;
  logic signed [47:0] c_i = '0, pcin_i = '0;
  logic [4:0] mode_i = '0;
  logic signed [47:0] pcout_a, p_a, pcout_b;
  logic signed [43:0] p_b;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  pre_add_mac i_pre_add_mac (
    .clk_i, .rst_ni, .ce1_i, .ce2_i, .cem_i, .cep_i, .a_i, .b_i, .c_i, .d_i,
    .mode_i, .pcin_i, .pcout_o(pcout_a), .p_o(p_a)
  );

  pre_add_mac #(.USE_PREADD(0), .S(4)) i_pre_add_mac_narrow (
    .clk_i, .rst_ni, .ce1_i, .ce2_i, .cem_i, .cep_i, .a_i, .b_i, .c_i, .d_i,
    .mode_i, .pcin_i, .pcout_o(pcout_b), .p_o(p_b)
  );

  typedef struct {
    longint a1, d1, b1, c1; logic [4:0] mo1;
    longint ad2, b2, c2;    logic [4:0] mo2;
    longint m3, c3;         logic [4:0] mo3;
    logic [47:0] p;
  } mdl_t;

  mdl_t ma, mb;

  function automatic mdl_t mdl_clear();
    mdl_t n;
    n.a1 = 0; n.d1 = 0; n.b1 = 0; n.c1 = 0; n.mo1 = '0;
    n.ad2 = 0; n.b2 = 0; n.c2 = 0; n.mo2 = '0;
    n.m3 = 0; n.c3 = 0; n.mo3 = '0; n.p = '0;
    return n;
  endfunction

  function automatic mdl_t mdl_step(mdl_t s, bit pa);
    mdl_t n = s;
    longint z, r;
    if (cep_i) begin
      case (s.mo3[3:2])
        2'd0: z = 0;
        2'd1: z = longint'(pcin_i);
        2'd2: z = longint'({16'd0, s.p});
        default: z = s.c3;
      endcase
      case (s.mo3[1:0])
        2'd0: r = z + s.m3;
        2'd1: r = s.m3 - z;
        2'd2: r = -(z + s.m3 + 1);
        default: r = z - s.m3;
      endcase
      n.p = r[47:0];
    end
    if (cem_i) begin
      n.m3 = s.b2 * s.ad2; n.c3 = s.c2; n.mo3 = s.mo2;
    end
    if (pa && ce2_i) begin
      n.ad2 = s.mo1[4] ? s.a1 - s.d1 : s.a1 + s.d1;
      n.b2 = s.b1; n.c2 = s.c1; n.mo2 = s.mo1;
    end
    if (ce1_i) begin
      n.a1 = longint'(a_i); n.d1 = longint'(d_i); n.b1 = longint'(b_i);
      n.c1 = longint'(c_i); n.mo1 = mode_i;
    end
    if (!pa) begin
      n.ad2 = n.a1; n.b2 = n.b1; n.c2 = n.c1; n.mo2 = n.mo1;
    end
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(pcout_a === ma.p, {tag, " preadd pcout"}, pcout_a, ma.p);
    chk(p_a === ma.p, {tag, " R7 preadd p"}, p_a, ma.p);
    chk(pcout_b === mb.p, {tag, " direct pcout"}, pcout_b, mb.p);
    chk(p_b === mb.p[47:4], {tag, " R7 direct p"}, {4'd0, p_b}, {4'd0, mb.p[47:4]});
  endtask

  task automatic cyc(input string tag);
    @(posedge clk_i);
    #1;
    ma = mdl_step(ma, 1'b1);
    mb = mdl_step(mb, 1'b0);
    compare(tag);
  endtask

  task automatic rand_ops();
    a_i = 25'($urandom); d_i = 25'($urandom); b_i = 18'($urandom);
    c_i = {16'($urandom), 32'($urandom)}; pcin_i = {16'($urandom), 32'($urandom)};
  endtask

  task automatic all_ce(input logic v);
    ce1_i = v; ce2_i = v; cem_i = v; cep_i = v;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    ma = mdl_clear();
    mb = mdl_clear();
    all_ce(1'b1);
    rand_ops();
    mode_i = 5'b11110;
    repeat (3) @(posedge clk_i);
    #1;
    compare("R1 reset");
    rst_ni = 1'b1;
    a_i = '0; d_i = '0; b_i = '0; c_i = '0; pcin_i = '0; mode_i = '0;

    // R5: single impulse, watch it emerge after 3 or 4 edges
    @(posedge clk_i); #1;
    a_i = 25'sd3; d_i = 25'sd4; b_i = 18'sd5; c_i = 48'sd11; mode_i = 5'b01100;
    cyc("R5 latency");
    a_i = '0; d_i = '0; b_i = '0; c_i = '0; mode_i = '0;
    for (int i = 0; i < 6; i++) cyc("R5 latency");

    // R2 R3 R4: random operands and modes, all stages enabled
    for (int i = 0; i < 300; i++) begin
      rand_ops(); mode_i = 5'($urandom);
      cyc("R2 R3 R4 R8");
    end

    // R6: random per-stage enables
    for (int i = 0; i < 300; i++) begin
      rand_ops(); mode_i = 5'($urandom);
      ce1_i = 1'($urandom); ce2_i = 1'($urandom); cem_i = 1'($urandom); cep_i = 1'($urandom);
      cyc("R6 enables");
    end
    all_ce(1'b1);

    // R10: restart with C then accumulate
    for (int k = 0; k < 3; k++) begin
      rand_ops(); mode_i = 5'b01100;
      cyc("R10 restart");
      for (int i = 0; i < 20; i++) begin
        a_i = 25'($urandom); d_i = 25'($urandom); b_i = 18'($urandom);
        mode_i = 5'b01000;
        cyc("R10 accumulate");
      end
    end

    // R8: extreme operands accumulate until the 48-bit result wraps
    a_i = -25'sd16777216; d_i = -25'sd16777216; b_i = -18'sd131072;
    c_i = '0; mode_i = 5'b01100;
    cyc("R8 wrap");
    mode_i = 5'b01000;
    for (int i = 0; i < 200; i++) cyc("R8 wrap");
    mode_i = 5'b01011;
    for (int i = 0; i < 100; i++) cyc("R8 wrap subtract");

    // R9: direct slice ignores D, pre-sub bit and ce2
    for (int i = 0; i < 60; i++) begin
      rand_ops(); mode_i = 5'($urandom);
      ce2_i = 1'($urandom);
      cyc("R9 no preadd");
    end
    all_ce(1'b1);
    mode_i = '0;
    for (int i = 0; i < 6; i++) cyc("R9 drain");

    done = 1;
    summary();
    $finish;
  end
endmodule